// File: doc/BRIEF.md
# Two-Priority Conversion Scan Sequencer

This block decides which analog channel a single converter samples next. Two channel-enable masks define a low-priority scan (sequence A) and a high-priority scan (sequence B). Each conversion is started with a one-cycle request that carries a channel index and the sequence it belongs to. The sequencer then waits for the converter's done strobe before it issues anything else. Only one conversion is ever outstanding.

Sequence A can run once per trigger or loop until stopped. Sequence B always runs once per trigger. When B is accepted while A is still scanning, B takes over as soon as the conversion in flight has finished. A then resumes in one of two ways, chosen by configuration: at the channel after the one it last converted, or from its lowest enabled channel. Three sticky flags report the end of an A scan, the end of a B scan and the preemption of A. The two end flags each have an interrupt enable.

The mode field uses this encoding: 0 = A runs once and B is off, 1 = A loops and B is off, 2 = A and B both run once, 3 = A loops and B runs once. The resume field uses 0 = continue and 1 = restart.

Top module: `scan_sequencer`

## Requirements
- R1: Within a scan, every channel whose mask bit is set is requested exactly once, in ascending index order. `conv_seq` is 0 for A and 1 for B.
- R2: `conv_req` is a one-cycle pulse. No new request is issued while an earlier one has not yet seen `conv_done`.
- R3: In modes 0 and 2, one A trigger produces a single pass over mask A. `eoc_a` is set after the pass and the sequencer then goes idle.
- R4: In modes 1 and 3, A restarts from its lowest enabled channel after each pass. `eoc_a` is set at each pass end, and scanning continues until stopped.
- R5: A B trigger accepted during an A scan lets the A conversion in flight finish. The next request after that is a B request, and A issues nothing until B has ended.
- R6: With resume = 0, a preempted A scan continues with the first enabled channel above the last one it converted.
- R7: With resume = 1, a preempted A scan starts again from its lowest enabled channel.
- R8: `nested` is set when a B trigger is accepted while an A scan is active. It stays set until `clr_nest` and is never set when A is idle.
- R9: B triggers are ignored in modes 0 and 1, and also while B is already running.
- R10: `sw_stop` lets the outstanding conversion finish and then ends both sequences. It issues no further request, sets no end flag, and drops `busy`.
- R11: Each flag has its own clear input, and a set in the same cycle wins. `irq_a`/`irq_b` are the end flags gated by their enables.
- R12: After reset no request is pending, `busy` is low and all flags are clear.
- R13: An A start (`start_a_trig` or `sw_start`) is ignored while A is active. Any trigger is also ignored when its mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Scan mode (0..3, see above) |
| cfg_resume | input | 1 | Resume policy after preemption: 0 continue, 1 restart |
| cfg_mask_a | input | NUM_CH | Channel enables of sequence A |
| cfg_mask_b | input | NUM_CH | Channel enables of sequence B |
| cfg_ie_a | input | 1 | Interrupt enable for the A end flag |
| cfg_ie_b | input | 1 | Interrupt enable for the B end flag |
| start_a_trig | input | 1 | Hardware trigger for sequence A |
| start_b_trig | input | 1 | Hardware trigger for sequence B |
| sw_start | input | 1 | Software start of sequence A |
| sw_stop | input | 1 | Software stop of both sequences |
| clr_eoc_a | input | 1 | Clear the A end flag |
| clr_eoc_b | input | 1 | Clear the B end flag |
| clr_nest | input | 1 | Clear the preemption flag |
| conv_done | input | 1 | Converter finished the outstanding conversion |
| conv_req | output | 1 | Start-of-conversion pulse |
| conv_ch | output | log2(NUM_CH) | Channel of the requested conversion |
| conv_seq | output | 1 | Sequence of the requested conversion (0 A, 1 B) |
| busy | output | 1 | A scan, B scan, conversion or stop is in progress |
| eoc_a | output | 1 | Sticky end-of-scan flag of A |
| eoc_b | output | 1 | Sticky end-of-scan flag of B |
| nested | output | 1 | Sticky flag: A was preempted by B |
| irq_a | output | 1 | A end interrupt |
| irq_b | output | 1 | B end interrupt |

## Verification
Acceptance of a B trigger and completion of an A conversion can fall on the same clock edge. One edge then both frees the converter and decides where A will resume. The bench waits for the converter model's done pulse and raises the B trigger in that same cycle, with the restart policy selected. It then requires the request order A, B, and then A again from its lowest channel, and it requires `nested` to be set. A separate test raises a B trigger while an A conversion is in flight. That test checks that the in-flight channel is treated as done under the continue policy and is not converted again.

// File: rtl/scan_seq_pkg.sv
// Shared types of the scan sequencer: mode encoding and sequence tags.
package scan_seq_pkg;
    // Mode field: bit 1 enables sequence B, bit 0 makes sequence A loop.
    typedef enum logic [1:0] {
        MODE_A_ONCE        = 2'd0,
        MODE_A_LOOP        = 2'd1,
        MODE_AB_ONCE       = 2'd2,
        MODE_A_LOOP_B_ONCE = 2'd3
    } scan_mode_e;

    // Tag carried with every request.
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } seq_src_e;

    localparam int NUM_SEQ  = 2;
    localparam int NUM_FLAG = 3;
endpackage

// File: rtl/chan_picker.sv
// Finds the lowest set mask bit whose index is at or above a start point.
// Assumes START_W can hold NUM_CH so that "past the last channel" is encodable.
module chan_picker #(
    parameter int NUM_CH  = 16,
    parameter int CH_W    = 4,
    parameter int START_W = 5
) (
    input  logic [NUM_CH-1:0]  mask,
    input  logic [START_W-1:0] start,
    output logic               found,
    output logic [CH_W-1:0]    idx
);
    // Priority search from the top so the lowest qualifying index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(start))) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/sticky_flag.sv
// Set/clear status bit; a set in the same cycle as a clear wins.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag until an explicit clear without a competing set.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/scan_sequencer.sv
// Two-priority scan sequencer for one converter.
// Sequence B preempts sequence A between conversions; A resumes per cfg_resume.
// Assumes the converter answers each conv_req with exactly one conv_done pulse
// and that masks and mode are held stable while a scan is active.
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cfg_mode,
    input  logic                      cfg_resume,
    input  logic [NUM_CH-1:0]         cfg_mask_a,
    input  logic [NUM_CH-1:0]         cfg_mask_b,
    input  logic                      cfg_ie_a,
    input  logic                      cfg_ie_b,
    input  logic                      start_a_trig,
    input  logic                      start_b_trig,
    input  logic                      sw_start,
    input  logic                      sw_stop,
    input  logic                      clr_eoc_a,
    input  logic                      clr_eoc_b,
    input  logic                      clr_nest,
    input  logic                      conv_done,
    output logic                      conv_req,
    output logic [$clog2(NUM_CH)-1:0] conv_ch,
    output logic                      conv_seq,
    output logic                      busy,
    output logic                      eoc_a,
    output logic                      eoc_b,
    output logic                      nested,
    output logic                      irq_a,
    output logic                      irq_b
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int NXT_W = CH_W + 1;

    scan_mode_e mode;
    logic a_act, b_act, a_rew, cbusy, stop_pend;
    logic [NXT_W-1:0] a_next, b_next;

    logic [NUM_SEQ-1:0][NUM_CH-1:0] masks;
    logic [NUM_SEQ-1:0][NXT_W-1:0]  starts;
    logic [NUM_SEQ-1:0]             found;
    logic [NUM_SEQ-1:0][CH_W-1:0]   pick;

    logic stopping, slot_free, b_on, a_loop;
    logic launch_a, launch_b, end_a, end_b, wrap_a;
    logic acc_a, acc_b, preempt;

    assign mode      = scan_mode_e'(cfg_mode);
    assign b_on      = (mode == MODE_AB_ONCE) || (mode == MODE_A_LOOP_B_ONCE);
    assign a_loop    = (mode == MODE_A_LOOP) || (mode == MODE_A_LOOP_B_ONCE);

    // Search inputs: A starts at zero when a restart is owed.
    assign masks[0]  = cfg_mask_a;
    assign masks[1]  = cfg_mask_b;
    assign starts[0] = a_rew ? '0 : a_next;
    assign starts[1] = b_next;

    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_pick
        chan_picker #(.NUM_CH(NUM_CH), .CH_W(CH_W), .START_W(NXT_W)) u_pick (
            .mask  (masks[g]),
            .start (starts[g]),
            .found (found[g]),
            .idx   (pick[g])
        );
    end

    // Slot decisions: B has priority; a failed search ends that sequence's pass.
    assign stopping  = stop_pend | sw_stop;
    assign slot_free = !cbusy && !stopping;
    assign launch_b  = slot_free && b_act && found[1];
    assign end_b     = slot_free && b_act && !found[1];
    assign launch_a  = slot_free && !b_act && a_act && found[0];
    assign end_a     = slot_free && !b_act && a_act && !found[0];
    assign wrap_a    = end_a && a_loop && !a_rew && (a_next != '0);

    // Trigger acceptance.
    assign acc_a   = (start_a_trig || sw_start) && !a_act && !stopping && (|cfg_mask_a);
    assign acc_b   = start_b_trig && b_on && !b_act && !stopping && (|cfg_mask_b);
    assign preempt = acc_b && a_act && !end_a;

    // Scan state, request issue and stop handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_act     <= 1'b0;
            b_act     <= 1'b0;
            a_rew     <= 1'b0;
            cbusy     <= 1'b0;
            stop_pend <= 1'b0;
            a_next    <= '0;
            b_next    <= '0;
            conv_req  <= 1'b0;
            conv_ch   <= '0;
            conv_seq  <= SRC_A;
        end else begin
            conv_req <= 1'b0;
            if (launch_b) begin
                conv_req <= 1'b1;
                conv_ch  <= pick[1];
                conv_seq <= SRC_B;
                cbusy    <= 1'b1;
                b_next   <= NXT_W'(pick[1]) + NXT_W'(1);
            end else if (launch_a) begin
                conv_req <= 1'b1;
                conv_ch  <= pick[0];
                conv_seq <= SRC_A;
                cbusy    <= 1'b1;
                a_next   <= NXT_W'(pick[0]) + NXT_W'(1);
                a_rew    <= 1'b0;
            end
            if (cbusy && conv_done) cbusy <= 1'b0;
            if (sw_stop) begin
                stop_pend <= 1'b1;
            end else if (stop_pend && !cbusy) begin
                stop_pend <= 1'b0;
                a_act     <= 1'b0;
                b_act     <= 1'b0;
                a_rew     <= 1'b0;
            end
            if (end_b) b_act <= 1'b0;
            if (end_a) begin
                if (wrap_a) a_next <= '0;
                else        a_act  <= 1'b0;
                a_rew <= 1'b0;
            end
            if (acc_a) begin
                a_act  <= 1'b1;
                a_next <= '0;
                a_rew  <= 1'b0;
            end
            if (acc_b) begin
                b_act  <= 1'b1;
                b_next <= '0;
                if (preempt && cfg_resume) a_rew <= 1'b1;
            end
        end
    end

    // Status flags: end of A, end of B, preemption of A.
    logic [NUM_FLAG-1:0] f_set, f_clr, f_q;
    assign f_set = {preempt, end_b, end_a};
    assign f_clr = {clr_nest, clr_eoc_b, clr_eoc_a};

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        sticky_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (f_set[f]),
            .clr  (f_clr[f]),
            .flag (f_q[f])
        );
    end

    assign eoc_a  = f_q[0];
    assign eoc_b  = f_q[1];
    assign nested = f_q[2];
    assign irq_a  = f_q[0] & cfg_ie_a;
    assign irq_b  = f_q[1] & cfg_ie_b;
    assign busy   = a_act | b_act | cbusy | stop_pend;
endmodule

// File: rtl/scan_sequencer_chk.sv
// Protocol and flag checks for scan_sequencer, attached with bind.
module scan_sequencer_chk #(
    parameter int NUM_CH = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                cfg_mode,
    input logic [NUM_CH-1:0]         cfg_mask_a,
    input logic                      start_b_trig,
    input logic                      clr_eoc_a,
    input logic                      conv_done,
    input logic                      conv_req,
    input logic [$clog2(NUM_CH)-1:0] conv_ch,
    input logic                      conv_seq,
    input logic                      busy,
    input logic                      eoc_a,
    input logic                      nested
);
    logic out_q;

    // Track an outstanding conversion as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_q <= 1'b0;
        else if (conv_req)  out_q <= 1'b1;
        else if (conv_done) out_q <= 1'b0;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> !out_q); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req); // R2
    AST_A_CH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_seq) |-> cfg_mask_a[conv_ch]); // R1
    AST_NO_B_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !cfg_mode[1]) |-> !conv_seq); // R9
    AST_NEST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nested) |-> $past(start_b_trig)); // R8
    AST_EOCA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_a) |-> $past(clr_eoc_a)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy); // R10
endmodule

bind scan_sequencer scan_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_mask_a  (cfg_mask_a),
    .start_b_trig(start_b_trig),
    .clr_eoc_a   (clr_eoc_a),
    .conv_done   (conv_done),
    .conv_req    (conv_req),
    .conv_ch     (conv_ch),
    .conv_seq    (conv_seq),
    .busy        (busy),
    .eoc_a       (eoc_a),
    .nested      (nested)
);

// File: tb/scan_sequencer_tb_top.sv
// Directed bench: one task per scenario, a converter model with fixed latency,
// and a log of every request encoded as seq*100 + channel.
module scan_sequencer_tb_top;
    localparam int NUM_CH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic cfg_resume = 1'b0;
    logic [NUM_CH-1:0] cfg_mask_a = '0, cfg_mask_b = '0;
    logic cfg_ie_a = 1'b0, cfg_ie_b = 1'b0;
    logic start_a_trig = 1'b0, start_b_trig = 1'b0, sw_start = 1'b0, sw_stop = 1'b0;
    logic clr_eoc_a = 1'b0, clr_eoc_b = 1'b0, clr_nest = 1'b0;
    logic conv_done;
    logic conv_req, conv_seq, busy, eoc_a, eoc_b, nested, irq_a, irq_b;
    logic [3:0] conv_ch;

    int n_chk = 0, n_fail = 0, n_log = 0, cyc = 0, cnt = 0;
    int log_code [0:255];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    scan_sequencer #(.NUM_CH(NUM_CH)) dut_i (.*);

    // Converter model: done pulse four edges after the request edge; request log.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= 0;
            conv_done <= 1'b0;
        end else begin
            conv_done <= (cnt == 1);
            if (conv_req) begin
                cnt <= 3;
                log_code[n_log & 255] <= (conv_seq ? 100 : 0) + int'(conv_ch);
                n_log <= n_log + 1;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_log(input int target);
        int t = 0;
        while (n_log < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic wait_idle;
        int t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (busy && t < 5000);
        tick(3);
    endtask

    task automatic cmp_log(input string req, input int base, input int exp[$]);
        int bad = -1;
        chk(req, "request count", n_log - base, exp.size());
        for (int i = 0; i < exp.size() && i < n_log - base; i++)
            if (bad < 0 && log_code[(base + i) & 255] != exp[i]) bad = i;
        if (bad >= 0) chk(req, "request order", log_code[(base + bad) & 255], exp[bad]);
        else          chk(req, "request order", 0, 0);
    endtask

    task automatic clear_flags;
        clr_eoc_a = 1'b1; clr_eoc_b = 1'b1; clr_nest = 1'b1;
        tick(1);
        clr_eoc_a = 1'b0; clr_eoc_b = 1'b0; clr_nest = 1'b0;
        tick(1);
    endtask

    task automatic pulse_a;  start_a_trig = 1'b1; tick(1); start_a_trig = 1'b0; endtask
    task automatic pulse_b;  start_b_trig = 1'b1; tick(1); start_b_trig = 1'b0; endtask
    task automatic pulse_stop; sw_stop = 1'b1; tick(1); sw_stop = 1'b0; endtask

    task automatic t_reset;
        chk("R12", "conv_req after reset", int'(conv_req), 0);
        chk("R12", "busy after reset", int'(busy), 0);
        chk("R12", "flags after reset", int'({eoc_a, eoc_b, nested}), 0);
    endtask

    // R1 R3 R11: single pass in ascending order, interrupt gating.
    task automatic t_single_pass;
        int base = n_log;
        cfg_mode = 2'd0; cfg_mask_a = 16'h00A5; cfg_ie_a = 1'b1;
        pulse_a();
        wait_idle();
        cmp_log("R1", base, '{0, 2, 5, 7});
        chk("R3", "eoc_a after pass", int'(eoc_a), 1);
        chk("R3", "busy after pass", int'(busy), 0);
        chk("R11", "irq_a with enable", int'(irq_a), 1);
        cfg_ie_a = 1'b0; tick(1);
        chk("R11", "irq_a masked", int'(irq_a), 0);
        clr_eoc_a = 1'b1; tick(1); clr_eoc_a = 1'b0; tick(1);
        chk("R11", "eoc_a cleared", int'(eoc_a), 0);
    endtask

    // R4 R10: continuous rescans, then stop after the in-flight conversion.
    task automatic t_loop_stop;
        int base = n_log;
        clear_flags();
        cfg_mode = 2'd1; cfg_mask_a = 16'h000A;
        pulse_a();
        wait_log(base + 5);
        pulse_stop();
        wait_idle();
        tick(20);
        cmp_log("R4", base, '{1, 3, 1, 3, 1});
        chk("R4", "eoc_a after first pass", int'(eoc_a), 1);
        chk("R10", "busy after stop", int'(busy), 0);
    endtask

    // R10: stop in the middle of a single pass sets no flag.
    task automatic t_stop_mid;
        int base = n_log;
        clear_flags();
        cfg_mode = 2'd0; cfg_mask_a = 16'h00FF;
        pulse_a();
        wait_log(base + 2);
        pulse_stop();
        wait_idle();
        tick(20);
        chk("R10", "requests after stop", n_log - base, 2);
        chk("R10", "eoc_a after abort", int'(eoc_a), 0);
    endtask

    // R5 R6 R8: preemption with continue policy.
    task automatic t_preempt_continue;
        int base = n_log;
        clear_flags();
        cfg_mode = 2'd2; cfg_resume = 1'b0; cfg_mask_a = 16'h000F; cfg_mask_b = 16'h0300;
        pulse_a();
        wait_log(base + 2);
        pulse_b();
        wait_idle();
        cmp_log("R6", base, '{0, 1, 108, 109, 2, 3});
        chk("R8", "nested after preemption", int'(nested), 1);
        chk("R5", "eoc_b after B", int'(eoc_b), 1);
        // R11: clearing one flag leaves the others.
        clr_eoc_b = 1'b1; tick(1); clr_eoc_b = 1'b0; tick(1);
        chk("R11", "eoc_b cleared alone", int'(eoc_b), 0);
        chk("R11", "eoc_a kept", int'(eoc_a), 1);
        chk("R11", "nested kept", int'(nested), 1);
        clr_nest = 1'b1; tick(1); clr_nest = 1'b0; tick(1);
        chk("R8", "nested cleared", int'(nested), 0);
    endtask

    // R7: preemption with restart policy.
    task automatic t_preempt_restart;
        int base = n_log;
        clear_flags();
        cfg_mode = 2'd2; cfg_resume = 1'b1; cfg_mask_a = 16'h000F; cfg_mask_b = 16'h0300;
        pulse_a();
        wait_log(base + 2);
        pulse_b();
        wait_idle();
        cmp_log("R7", base, '{0, 1, 108, 109, 0, 1, 2, 3});
    endtask

    // R5 R7: B trigger in the same cycle as an A done.
    task automatic t_same_cycle;
        int base = n_log;
        int t = 0;
        clear_flags();
        cfg_mode = 2'd2; cfg_resume = 1'b1; cfg_mask_a = 16'h0050; cfg_mask_b = 16'h0400;
        pulse_a();
        wait_log(base + 1);
        while (!conv_done && t < 100) begin @(negedge clk); t++; end
        pulse_b();
        wait_idle();
        cmp_log("R5", base, '{4, 110, 4, 6});
        chk("R8", "nested on same-cycle preemption", int'(nested), 1);
    endtask

    // R9 R13: ignored triggers.
    task automatic t_ignored;
        int base;
        clear_flags();
        base = n_log;
        cfg_mode = 2'd0; cfg_mask_b = 16'h0003;
        pulse_b(); tick(10);
        chk("R9", "B requests in mode 0", n_log - base, 0);
        chk("R9", "eoc_b in mode 0", int'(eoc_b), 0);
        base = n_log;
        cfg_mode = 2'd2; cfg_mask_a = '0; cfg_mask_b = 16'h000E;
        pulse_b();
        wait_log(base + 1);
        pulse_b();
        wait_idle();
        cmp_log("R9", base, '{101, 102, 103});
        chk("R8", "nested with A idle", int'(nested), 0);
        base = n_log;
        cfg_mode = 2'd0; cfg_mask_a = 16'h0060;
        pulse_a();
        wait_log(base + 1);
        sw_start = 1'b1; tick(1); sw_start = 1'b0;
        wait_idle();
        cmp_log("R13", base, '{5, 6});
        base = n_log;
        cfg_mask_a = '0;
        pulse_a(); tick(1);
        chk("R13", "busy on empty mask", int'(busy), 0);
        tick(10);
        chk("R13", "requests on empty mask", n_log - base, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_single_pass();
        t_loop_stop();
        t_stop_mid();
        t_preempt_continue();
        t_preempt_restart();
        t_same_cycle();
        t_ignored();
        finished = 1'b1;
        report();
        $finish;
    end
endmodule